// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a master for a three-wire serial EEPROM that stores 16-bit words. It drives the chip select, serial clock and data-in lines and samples the data-out line. After reset it runs a sizing pass on its own. The pass sends the read command, then clocks in zero address bits one at a time until the device answers with its dummy zero. The number of bits sent up to that point becomes the address width used for every later read.

Once sizing is over, the host asks for a burst with a one-cycle start pulse, a start word offset and a word count. Each word is read in its own chip-select frame: the read command, then the word address, then sixteen data bits. The word is then offered on a valid/ready output. A one-cycle done pulse marks the end of the burst. All serial clock phases come from a divider of the system clock, so that each phase lasts long enough for slow parts.

Top module: `mwire_rd_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, busy is 1, rd_valid and done are 0 and ee_cs is 1, because the sizing pass starts on its own.
- R2: The sizing pass sends the read command 3'b110, MSB first, and then zero probe bits. The address width is the number of probe bits sent when data-out first reads 0. With an 8-bit device, addr_bits becomes 8 and size_err becomes 0.
- R3: With a device that answers after 6 probe bits, addr_bits becomes 6 and size_err becomes 0.
- R4: If data-out stays 1 through 8 probe bits, size_err becomes 1 and addr_bits becomes 8.
- R5: Each word frame sends the command 3'b110 and then the word address, both MSB first. The address uses addr_bits bits. The frame then clocks in 16 data bits, each sampled at the end of a serial-clock high phase. The first bit received lands in rd_data bit 15.
- R6: The address of word k in a burst is (offset + k) modulo 2^addr_bits.
- R7: Each word of a burst gets exactly one chip-select frame, and ee_cs is 0 while a finished word waits on the output.
- R8: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data holds its value.
- R9: done is 1 for exactly one cycle, in the cycle after the handshake of the last word, and busy is 0 in that cycle.
- R10: A start pulse while busy is 1 has no effect: the running burst delivers its own words only, and no frame follows its done.
- R11: A start pulse with count 0 gives done in the next cycle and starts no frame.
- R12: Every high phase and every low phase of ee_sk lasts at least HALF_CYC system clocks, and ee_sk is high only while ee_cs is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle burst request |
| offset | input | MAX_ABITS | First word address of the burst |
| count | input | MAX_ABITS+1 | Number of words in the burst |
| busy | output | 1 | Sizing pass or burst in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |
| size_err | output | 1 | Sizing pass found no dummy zero |
| addr_bits | output | clog2(MAX_ABITS+1) | Address width found by sizing |
| rd_data | output | 16 | Word read from the device |
| rd_valid | output | 1 | rd_data holds a word |
| rd_ready | input | 1 | Host accepts the word |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
The device model answers sizing after 6 bits, after 8 bits, or never. These three cases tell a correct count of probe bits from a count that is off by one, and they also exercise the fallback. Burst reads use word contents that differ between the two bytes and from address to address. Any swap of bit order, any wrong address or any extra or missing word then shows up as a data mismatch. An offset near the top of the 6-bit space checks the address wrap. Held-off ready, a start request made in the middle of a burst, and a zero count each separate output stalling, request filtering and the empty-burst path from the normal flow.

// File: rtl/mwire_pkg.sv
package mwire_pkg;

    localparam int WORD_W = 16;
    localparam int BIDX_W = $clog2(WORD_W);
    localparam logic [2:0] RD_OPCODE = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_LO,
        ST_HI,
        ST_HAND,
        ST_GAP
    } mw_state_e;

    typedef enum logic [1:0] {
        SEG_OPC,
        SEG_ADDR,
        SEG_PROBE,
        SEG_DATA
    } mw_seg_e;

    function automatic logic pick_bit(input logic [WORD_W-1:0] v, input logic [BIDX_W-1:0] i);
        return v[i];
    endfunction

endpackage

// File: rtl/mwire_phase_timer.sv
module mwire_phase_timer #(
    parameter int HALF_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int TW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(HALF_CYC - 1);

    logic [TW-1:0] cnt;

    assign expire = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= RELOAD;
        end else if (cnt == '0) begin
            cnt <= RELOAD;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/mwire_sync.sv
module mwire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mwire_engine.sv
module mwire_engine
    import mwire_pkg::*;
#(
    parameter int MAX_ABITS = 8,
    parameter int AB_W      = $clog2(MAX_ABITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [MAX_ABITS-1:0] offset,
    input  logic [MAX_ABITS:0]   count,
    input  logic                 expire,
    input  logic                 do_s,
    input  logic                 rd_ready,
    output logic                 run,
    output logic                 busy,
    output logic                 done,
    output logic                 size_err,
    output logic [AB_W-1:0]      abits,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 cs,
    output logic                 sk,
    output logic                 di
);
    mw_state_e             st;
    mw_seg_e               seg;
    logic                  sizing;
    logic [BIDX_W-1:0]     bidx;
    logic [WORD_W-1:0]     shreg;
    logic [MAX_ABITS-1:0]  cur_addr;
    logic [MAX_ABITS:0]    left;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_SEL;
            seg      <= SEG_OPC;
            sizing   <= 1'b1;
            bidx     <= BIDX_W'(2);
            abits    <= AB_W'(MAX_ABITS);
            size_err <= 1'b0;
            shreg    <= '0;
            cur_addr <= '0;
            left     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (count == '0) begin
                            done <= 1'b1;
                        end else begin
                            cur_addr <= offset;
                            left     <= count;
                            st       <= ST_SEL;
                        end
                    end
                end
                ST_SEL: begin
                    if (expire) begin
                        st   <= ST_LO;
                        seg  <= SEG_OPC;
                        bidx <= BIDX_W'(2);
                    end
                end
                ST_LO: begin
                    if (expire) st <= ST_HI;
                end
                ST_HI: begin
                    if (expire) begin
                        st <= ST_LO;
                        unique case (seg)
                            SEG_OPC: begin
                                if (bidx == '0) begin
                                    if (sizing) begin
                                        seg  <= SEG_PROBE;
                                        bidx <= '0;
                                    end else begin
                                        seg  <= SEG_ADDR;
                                        bidx <= BIDX_W'(abits - 1'b1);
                                    end
                                end else begin
                                    bidx <= bidx - 1'b1;
                                end
                            end
                            SEG_ADDR: begin
                                if (bidx == '0) begin
                                    seg  <= SEG_DATA;
                                    bidx <= BIDX_W'(WORD_W - 1);
                                end else begin
                                    bidx <= bidx - 1'b1;
                                end
                            end
                            SEG_PROBE: begin
                                if (!do_s) begin
                                    abits    <= AB_W'(bidx) + 1'b1;
                                    size_err <= 1'b0;
                                    st       <= ST_GAP;
                                end else if (bidx == BIDX_W'(MAX_ABITS - 1)) begin
                                    abits    <= AB_W'(MAX_ABITS);
                                    size_err <= 1'b1;
                                    st       <= ST_GAP;
                                end else begin
                                    bidx <= bidx + 1'b1;
                                end
                            end
                            SEG_DATA: begin
                                shreg <= {shreg[WORD_W-2:0], do_s};
                                if (bidx == '0) begin
                                    st <= ST_HAND;
                                end else begin
                                    bidx <= bidx - 1'b1;
                                end
                            end
                            default: st <= ST_IDLE;
                        endcase
                    end
                end
                ST_HAND: begin
                    if (rd_ready) begin
                        cur_addr <= cur_addr + 1'b1;
                        left     <= left - 1'b1;
                        if (left == (MAX_ABITS+1)'(1)) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            st <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (expire) begin
                        if (sizing) begin
                            sizing <= 1'b0;
                            st     <= ST_IDLE;
                        end else begin
                            st <= ST_SEL;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        run      = (st == ST_SEL) || (st == ST_LO) || (st == ST_HI) || (st == ST_GAP);
        busy     = (st != ST_IDLE);
        rd_valid = (st == ST_HAND);
        rd_data  = shreg;
        cs       = (st == ST_SEL) || (st == ST_LO) || (st == ST_HI);
        sk       = (st == ST_HI);
        di       = 1'b0;
        if ((st == ST_LO) || (st == ST_HI)) begin
            if (seg == SEG_OPC) begin
                di = RD_OPCODE[bidx[1:0]];
            end else if (seg == SEG_ADDR) begin
                di = pick_bit(WORD_W'(cur_addr), bidx);
            end
        end
    end
endmodule

// File: rtl/mwire_rd_ctrl.sv
module mwire_rd_ctrl
    import mwire_pkg::*;
#(
    parameter int HALF_CYC    = 100,
    parameter int MAX_ABITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic [MAX_ABITS-1:0]            offset,
    input  logic [MAX_ABITS:0]              count,
    output logic                            busy,
    output logic                            done,
    output logic                            size_err,
    output logic [$clog2(MAX_ABITS+1)-1:0]  addr_bits,
    output logic [15:0]                     rd_data,
    output logic                            rd_valid,
    input  logic                            rd_ready,
    output logic                            ee_cs,
    output logic                            ee_sk,
    output logic                            ee_di,
    input  logic                            ee_do
);
    localparam int AB_W = $clog2(MAX_ABITS + 1);

    logic run;
    logic expire;
    logic do_s;

    mwire_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .expire (expire)
    );

    mwire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ee_do),
        .q   (do_s)
    );

    mwire_engine #(.MAX_ABITS(MAX_ABITS), .AB_W(AB_W)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .offset   (offset),
        .count    (count),
        .expire   (expire),
        .do_s     (do_s),
        .rd_ready (rd_ready),
        .run      (run),
        .busy     (busy),
        .done     (done),
        .size_err (size_err),
        .abits    (addr_bits),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .cs       (ee_cs),
        .sk       (ee_sk),
        .di       (ee_di)
    );
endmodule

// File: rtl/mwire_rd_ctrl_chk.sv
module mwire_rd_ctrl_chk #(
    parameter int HALF_CYC = 100
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [15:0] rd_data,
    input logic        ee_cs,
    input logic        ee_sk
);
    logic        sk_q;
    logic [15:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q <= 1'b0;
            held <= 16'(HALF_CYC);
        end else begin
            sk_q <= ee_sk;
            if (ee_sk != sk_q) begin
                held <= 16'd1;
            end else if (held != 16'hFFFF) begin
                held <= held + 1'b1;
            end
        end
    end

    // R8: a waiting word stays put until taken
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R7: no chip select while a word waits on the output
    a_r7_cs_low_on_valid: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !ee_cs);

    // R9: done only when idle and never together with a waiting word
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !rd_valid));

    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: serial clock only inside a frame
    a_r12_sk_in_frame: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);

    // R12: each serial clock level lasts at least HALF_CYC cycles
    a_r12_phase_len: assert property (@(posedge clk) disable iff (rst)
        (ee_sk != sk_q) |-> (held >= 16'(HALF_CYC)));

    // R10: idle device lines when nothing is running
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ee_cs && !ee_sk));
endmodule

bind mwire_rd_ctrl mwire_rd_ctrl_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .ee_cs    (ee_cs),
    .ee_sk    (ee_sk)
);

// File: tb/mwire_rd_ctrl_bench.sv
`timescale 1ns/1ps
module mwire_rd_ctrl_bench;
    localparam int HALF = 4;
    localparam int MAXA = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  offset = '0;
    logic [8:0]  count = '0;
    logic        busy, done, size_err, rd_valid, ee_cs, ee_sk, ee_di;
    logic [3:0]  addr_bits;
    logic [15:0] rd_data;
    logic        rd_ready = 1'b0;
    logic        ee_do = 1'b1;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    int bad_opc = 0;
    int model_n = 8;
    int m_cnt = 0;
    logic [2:0] m_opc = '0;
    logic [7:0] m_addr = '0;
    int hi_run = 0, lo_run = 0;
    int min_hi = 1000, min_lo = 1000;

    always #5 clk = ~clk;

    mwire_rd_ctrl #(.HALF_CYC(HALF), .MAX_ABITS(MAXA)) u_mwire_rd_ctrl (
        .clk(clk), .rst(rst), .start(start), .offset(offset), .count(count),
        .busy(busy), .done(done), .size_err(size_err), .addr_bits(addr_bits),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        return {a ^ 8'hC3, a + 8'h1D};
    endfunction

    // device model: command, address, dummy zero, then 16 bits MSB first
    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            m_cnt  = 0;
            m_opc  = '0;
            m_addr = '0;
            ee_do  = 1'b1;
        end else begin
            m_cnt = m_cnt + 1;
            if (m_cnt <= 3) begin
                m_opc = {m_opc[1:0], ee_di};
                if (m_cnt == 3 && m_opc != 3'b110) bad_opc = bad_opc + 1;
            end else if (m_cnt <= 3 + model_n) begin
                m_addr = {m_addr[6:0], ee_di};
            end
            if (model_n != 0 && m_cnt == 3 + model_n) begin
                ee_do = 1'b0;
            end else if (model_n != 0 && m_cnt > 3 + model_n && m_cnt <= 19 + model_n) begin
                ee_do = mem_word(m_addr)[19 + model_n - m_cnt];
            end else begin
                ee_do = 1'b1;
            end
        end
    end

    always @(posedge ee_cs) frames = frames + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (ee_sk) begin
                hi_run = hi_run + 1;
                if (lo_run > 0 && ee_cs && lo_run < min_lo) min_lo = lo_run;
                lo_run = 0;
            end else begin
                if (hi_run > 0 && hi_run < min_hi) min_hi = hi_run;
                hi_run = 0;
                if (ee_cs) lo_run = lo_run + 1;
                else lo_run = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset_size(input int n, input int exp_ab, input bit exp_err, input string req);
        model_n = n;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b1 && rd_valid == 1'b0 && done == 1'b0 && ee_cs == 1'b1,
              "R1 reset state", {busy, rd_valid, done, ee_cs}, 4'b1001);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b1 && ee_cs == 1'b1, "R1 sizing starts", {busy, ee_cs}, 2'b11);
        wait_idle();
        check(busy == 1'b0, "R1 sizing ends", busy, 0);
        check(addr_bits == 4'(exp_ab), req, addr_bits, exp_ab);
        check(size_err == exp_err, req, size_err, exp_err);
    endtask

    task automatic t_burst(input logic [7:0] off, input int cnt, input bit stall, input bit poke,
                           input string req);
        int f0;
        int mask;
        mask = (1 << addr_bits) - 1;
        f0 = frames;
        bad_opc = 0;
        @(negedge clk);
        offset = off;
        count = 9'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < cnt; k++) begin
            for (int w = 0; w < 2000 && !rd_valid; w++) @(negedge clk);
            check(rd_valid == 1'b1, "R5 word offered", rd_valid, 1);
            check(rd_data == mem_word(8'((off + k) & mask)), req, rd_data,
                  mem_word(8'((off + k) & mask)));
            check(ee_cs == 1'b0, "R7 cs low while word waits", ee_cs, 0);
            if (poke && k == 0) begin
                offset = 8'h40;
                count = 9'd5;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            if (stall) begin
                repeat (3) @(negedge clk);
                check(rd_valid == 1'b1 && rd_data == mem_word(8'((off + k) & mask)),
                      "R8 held under stall", rd_data, mem_word(8'((off + k) & mask)));
            end
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
            if (k == cnt - 1) begin
                check(done == 1'b1 && busy == 1'b0, "R9 done after last word", {done, busy}, 2'b10);
                @(negedge clk);
                check(done == 1'b0, "R9 done one cycle", done, 0);
            end
        end
        check(frames - f0 == cnt, "R7 one frame per word", frames - f0, cnt);
        check(bad_opc == 0, "R5 read command 110", bad_opc, 0);
        if (poke) begin
            f0 = frames;
            repeat (300) begin
                @(negedge clk);
                if (rd_valid || busy) break;
            end
            check(rd_valid == 1'b0 && busy == 1'b0 && frames == f0,
                  "R10 start while busy ignored", {rd_valid, busy}, 0);
        end
    endtask

    task automatic t_zero_count();
        int f0;
        f0 = frames;
        @(negedge clk);
        offset = 8'h05;
        count = 9'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && busy == 1'b0, "R11 zero count done", {done, busy}, 2'b10);
        repeat (50) @(negedge clk);
        check(frames == f0 && busy == 1'b0, "R11 no frame", frames - f0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=%0h expected=%0h", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_size(0, 8, 1'b1, "R4 no dummy zero fallback");
        t_reset_size(8, 8, 1'b0, "R2 8-bit device width");
        t_burst(8'h10, 3, 1'b0, 1'b0, "R5 data MSB first");
        t_burst(8'hFE, 3, 1'b1, 1'b0, "R6 8-bit address wrap");
        t_burst(8'h21, 2, 1'b0, 1'b1, "R10 running burst data");
        t_zero_count();
        t_reset_size(6, 6, 1'b0, "R3 6-bit device width");
        t_burst(8'd62, 4, 1'b1, 1'b0, "R6 6-bit address wrap");
        check(min_hi >= HALF, "R12 sk high phase", min_hi, HALF);
        check(min_lo >= HALF, "R12 sk low phase", min_lo, HALF);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule